// File: doc/BRIEF.md
# Multi-Mode Timer/Counter with Auto-Reload

This block is a byte-organised timer/counter built from a low byte and a high byte. Software selects one of four counting arrangements: a 13-bit counter, a 16-bit counter, an 8-bit counter that refills itself from the high byte, or two separate 8-bit counters. Counting is enabled by a run bit. A gate bit can make counting also depend on the level of a gate input. The count source is either the system clock divided by 12 or by 4, or falling edges on an external count input after synchronisation.

On overflow the block sets a request flag, which drives an interrupt output. An acknowledge input clears the flag, and software can also write the flag directly. In split mode the high byte counts prescaler ticks on its own and keeps a second flag with its own acknowledge. A byte-wide register port gives read and write access to both count bytes and the control byte. A register write lands in the same cycle in which it is applied and takes precedence over a count in that cycle.

Top module: `cnt_timer_unit`

## Requirements
- R1: After a synchronous reset, the low byte, the high byte and the control byte all read 0x00, and both interrupt outputs are low.
- R2: The register map is address 0 for the low byte, 1 for the high byte and 2 for control. Address 3 reads 0x00 and a write to it changes nothing. The control bits are: [1:0] mode (0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split), [2] external source select, [3] gate enable, [4] run, [5] fast prescale (1 = /4, 0 = /12), [6] main flag, [7] high-byte flag. Every bit reads back as written.
- R3: While run is 0, neither count byte changes unless software writes it.
- R4: With the internal source, the count advances once every 12 clocks (fast = 0) or every 4 clocks (fast = 1) of run being high. The first advance comes on the 12th (or 4th) clock edge after the edge that sets run.
- R5: With gate enable at 1, the counter advances only while the gate input is high. With gate enable at 0, the gate input has no effect.
- R6: With external source select at 1, the counter advances once for each falling edge of the count input, a few clocks after that edge. Rising edges do not advance it.
- R7: Mode 0 counts the 13-bit value {high byte, low byte[4:0]}. On the step from 0x1FFF to 0 it sets the main flag, and low byte bits [7:5] keep their value.
- R8: Mode 1 counts the 16-bit value {high, low}. On the step from 0xFFFF to 0 it sets the main flag.
- R9: In mode 2 the low byte counts. A step from 0xFF loads the high byte into the low byte and sets the main flag. The high byte is unchanged. With a preload of 0x7A there are 134 counts per overflow.
- R10: In mode 3 the low byte counts with the selected source and gating and sets the main flag when it wraps. The high byte counts prescaler ticks whenever run is 1, whatever the gate setting, and sets the high-byte flag when it wraps.
- R11: Each flag is set by its overflow and cleared by its acknowledge input. An overflow in the same cycle as an acknowledge leaves the flag set. A software write to control overrides both.
- R12: A software write to a count byte in the same cycle as a count takes precedence: the byte holds the written value after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 low, 1 high, 2 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| cnt_pin | input | 1 | External count input, counted on falling edges |
| gate_pin | input | 1 | Gate input, synchronous level |
| ack | input | 1 | Clears the main overflow flag |
| ack_hi | input | 1 | Clears the high-byte overflow flag |
| irq | output | 1 | Main overflow flag |
| irq_hi | output | 1 | High-byte overflow flag (split mode) |

## Verification
The bench uses the default divisors, 12 and 4, and two synchroniser stages. With these values every prescaled count lands on a clock edge the bench can compute, so the exact first-count edge can be checked for both rates. The /4 rate also brings the full 134-count reload period with a 0x7A preload within reach in 536 clocks, and the bench checks that against the 133-count point at the /12 rate. The two-stage synchroniser bounds the external-edge latency, so a fixed wait after each falling edge is enough to observe the count.

// File: rtl/cnt_timer_pkg.sv
`timescale 1ns/1ps
package cnt_timer_pkg;

    localparam int BYTE_W   = 8;
    localparam int LOW13_W  = 5;               // low-byte bits used in 13-bit mode
    localparam int WIDE13_W = BYTE_W + LOW13_W;
    localparam int WIDE16_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_13     = 2'd0,
        MODE_16     = 2'd1,
        MODE_RELOAD = 2'd2,
        MODE_SPLIT  = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } rsel_e;

    // control byte, msb first
    typedef struct packed {
        logic   flag_hi;
        logic   flag;
        logic   fast;
        logic   run;
        logic   gate;
        logic   ext;
        tmode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              ovf_lo;
        logic              ovf_hi;
    } cnt_nxt_t;

endpackage

// File: rtl/cnt_timer_presc.sv
`timescale 1ns/1ps
module cnt_timer_presc #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW   = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] lim;

    assign lim  = fast ? FAST_LIM : SLOW_LIM;
    assign tick = run && (phase_q >= lim);

    // phase restarts whenever run drops, so the first tick is a fixed
    // number of edges after run rises
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (phase_q >= lim) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/cnt_timer_edge.sv
`timescale 1ns/1ps
module cnt_timer_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin};
        end
    end

    assign fall = sh_q[STAGES] && !sh_q[STAGES-1];
endmodule

// File: rtl/cnt_timer_core.sv
`timescale 1ns/1ps
module cnt_timer_core
    import cnt_timer_pkg::*;
(
    input  tmode_e            mode,
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] hi,
    input  logic              tick_lo,
    input  logic              tick_hi,
    output cnt_nxt_t          nxt
);
    logic [WIDE13_W:0] sum13;
    logic [WIDE16_W:0] sum16;
    logic [BYTE_W:0]   sum_lo;
    logic [BYTE_W:0]   sum_hi;

    assign sum13  = {1'b0, hi, lo[LOW13_W-1:0]} + 1'b1;
    assign sum16  = {1'b0, hi, lo} + 1'b1;
    assign sum_lo = {1'b0, lo} + 1'b1;
    assign sum_hi = {1'b0, hi} + 1'b1;

    always_comb begin
        nxt.lo     = lo;
        nxt.hi     = hi;
        nxt.ovf_lo = 1'b0;
        nxt.ovf_hi = 1'b0;
        unique case (mode)
            MODE_13: if (tick_lo) begin
                nxt.lo     = {lo[BYTE_W-1:LOW13_W], sum13[LOW13_W-1:0]};
                nxt.hi     = sum13[WIDE13_W-1:LOW13_W];
                nxt.ovf_lo = sum13[WIDE13_W];
            end
            MODE_16: if (tick_lo) begin
                nxt.lo     = sum16[BYTE_W-1:0];
                nxt.hi     = sum16[WIDE16_W-1:BYTE_W];
                nxt.ovf_lo = sum16[WIDE16_W];
            end
            MODE_RELOAD: if (tick_lo) begin
                if (sum_lo[BYTE_W]) begin
                    nxt.lo     = hi;
                    nxt.ovf_lo = 1'b1;
                end else begin
                    nxt.lo = sum_lo[BYTE_W-1:0];
                end
            end
            MODE_SPLIT: begin
                if (tick_lo) begin
                    nxt.lo     = sum_lo[BYTE_W-1:0];
                    nxt.ovf_lo = sum_lo[BYTE_W];
                end
                if (tick_hi) begin
                    nxt.hi     = sum_hi[BYTE_W-1:0];
                    nxt.ovf_hi = sum_hi[BYTE_W];
                end
            end
        endcase
    end
endmodule

// File: rtl/cnt_timer_unit.sv
`timescale 1ns/1ps
module cnt_timer_unit
    import cnt_timer_pkg::*;
#(
    parameter int SLOW_DIV    = 12,
    parameter int FAST_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cnt_pin,
    input  logic       gate_pin,
    input  logic       ack,
    input  logic       ack_hi,
    output logic       irq,
    output logic       irq_hi
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] tl_q;
    logic [BYTE_W-1:0] th_q;
    rsel_e             sel;
    logic              wr_lo, wr_hi, wr_ctrl;
    logic              pre_tick, ext_fall, cnt_en, tick_lo, tick_hi;
    cnt_nxt_t          nxt;

    assign sel     = rsel_e'(reg_addr);
    assign wr_lo   = reg_wr && (sel == SEL_LO);
    assign wr_hi   = reg_wr && (sel == SEL_HI);
    assign wr_ctrl = reg_wr && (sel == SEL_CTRL);

    cnt_timer_presc #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .fast (ctrl_q.fast),
        .tick (pre_tick)
    );

    cnt_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (cnt_pin),
        .fall (ext_fall)
    );

    assign cnt_en  = ctrl_q.run && (!ctrl_q.gate || gate_pin);
    assign tick_lo = cnt_en && (ctrl_q.ext ? ext_fall : pre_tick);
    assign tick_hi = (ctrl_q.mode == MODE_SPLIT) && pre_tick;

    cnt_timer_core u_core (
        .mode    (ctrl_q.mode),
        .lo      (tl_q),
        .hi      (th_q),
        .tick_lo (tick_lo),
        .tick_hi (tick_hi),
        .nxt     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tl_q   <= '0;
            th_q   <= '0;
            ctrl_q <= '0;
        end else begin
            tl_q <= wr_lo ? reg_wdata : nxt.lo;
            th_q <= wr_hi ? reg_wdata : nxt.hi;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(reg_wdata);
            end else begin
                if (nxt.ovf_lo)      ctrl_q.flag    <= 1'b1;
                else if (ack)        ctrl_q.flag    <= 1'b0;
                if (nxt.ovf_hi)      ctrl_q.flag_hi <= 1'b1;
                else if (ack_hi)     ctrl_q.flag_hi <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_LO:   reg_rdata = tl_q;
            SEL_HI:   reg_rdata = th_q;
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_NONE: reg_rdata = '0;
        endcase
    end

    assign irq    = ctrl_q.flag;
    assign irq_hi = ctrl_q.flag_hi;
endmodule

// File: rtl/cnt_timer_chk.sv
`timescale 1ns/1ps
module cnt_timer_chk
    import cnt_timer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       run,
    input tmode_e     mode,
    input logic       wr_lo,
    input logic       wr_hi,
    input logic       wr_ctrl,
    input logic [7:0] wdata,
    input logic       ovf_lo,
    input logic       ack,
    input logic       flag,
    input logic [7:0] tl,
    input logic [7:0] th
);
    // R3: stopped counter keeps both bytes
    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> ($stable(tl) && $stable(th)));

    // R11: an overflow raises the main flag
    p_ovf_sets_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (ovf_lo && !wr_ctrl) |=> flag);

    // R11: acknowledge without a competing overflow clears it
    p_ack_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && !ovf_lo && !wr_ctrl) |=> !flag);

    // R12: a low-byte write beats any count in that cycle
    p_lo_write_wins_r12: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (tl == $past(wdata)));

    // R9: reload takes the high byte and leaves it alone
    p_reload_copy_r9: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_RELOAD) && ovf_lo && !wr_lo && !wr_hi)
        |=> ((tl == $past(th)) && $stable(th)));
endmodule

bind cnt_timer_unit cnt_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .mode    (ctrl_q.mode),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_ctrl (wr_ctrl),
    .wdata   (reg_wdata),
    .ovf_lo  (nxt.ovf_lo),
    .ack     (ack),
    .flag    (ctrl_q.flag),
    .tl      (tl_q),
    .th      (th_q)
);

// File: tb/cnt_timer_unit_test.sv
`timescale 1ns/1ps
module cnt_timer_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       cnt_pin, gate_pin, ack, ack_hi;
    logic       irq, irq_hi;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cnt_timer_unit uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ack(ack), .ack_hi(ack_hi), .irq(irq), .irq_hi(irq_hi)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        fast;
        logic [7:0]  tl;
        logic [7:0]  th;
        logic [15:0] cyc;
        logic [7:0]  etl;
        logic [7:0]  eth;
        logic        ef;
        logic        efh;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 8'hFE, 8'hFF, 16'd12,   8'hFF, 8'hFF, 1'b0, 1'b0},
        '{2'd1, 1'b0, 8'hFF, 8'hFF, 16'd12,   8'h00, 8'h00, 1'b1, 1'b0},
        '{2'd1, 1'b0, 8'hFF, 8'h12, 16'd12,   8'h00, 8'h13, 1'b0, 1'b0},
        '{2'd1, 1'b1, 8'h00, 8'h00, 16'd20,   8'h05, 8'h00, 1'b0, 1'b0},
        '{2'd0, 1'b0, 8'hFF, 8'hFF, 16'd12,   8'hE0, 8'h00, 1'b1, 1'b0},
        '{2'd0, 1'b0, 8'h3F, 8'h05, 16'd12,   8'h20, 8'h06, 1'b0, 1'b0},
        '{2'd2, 1'b0, 8'hFE, 8'h7A, 16'd24,   8'h7A, 8'h7A, 1'b1, 1'b0},
        '{2'd2, 1'b1, 8'h7A, 8'h7A, 16'd536,  8'h7A, 8'h7A, 1'b1, 1'b0},
        '{2'd2, 1'b0, 8'h7A, 8'h7A, 16'd1596, 8'hFF, 8'h7A, 1'b0, 1'b0},
        '{2'd3, 1'b0, 8'hFF, 8'hFF, 16'd12,   8'h00, 8'h00, 1'b1, 1'b1},
        '{2'd3, 1'b0, 8'h10, 8'h20, 16'd36,   8'h13, 8'h23, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic setup(input logic [1:0] mode, input logic fast, input logic gate,
                         input logic ext, input logic run,
                         input logic [7:0] tl, input logic [7:0] th);
        wr(2'd2, 8'h00);
        wr(2'd0, tl);
        wr(2'd1, th);
        wr(2'd2, {2'b00, fast, run, gate, ext, mode});
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0: return "R7 mode0";
            2'd1: return "R8 mode1";
            2'd2: return "R9 mode2";
            default: return "R10 mode3";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        vec_t v;
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        cnt_pin = 1'b0; gate_pin = 1'b0; ack = 1'b0; ack_hi = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1 low", d, 8'h00);
        rd(2'd1, d); chk("R1 high", d, 8'h00);
        rd(2'd2, d); chk("R1 ctrl", d, 8'h00);
        chk("R1 irq", {6'd0, irq_hi, irq}, 8'h00);

        // vector table; gate input held low with gate enable off (R5)
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            setup(v.mode, v.fast, 1'b0, 1'b0, 1'b1, v.tl, v.th);
            repeat (int'(v.cyc)) @(negedge clk);
            rd(2'd0, d); chk({mode_req(v.mode), " low"}, d, v.etl);
            rd(2'd1, d); chk({mode_req(v.mode), " high"}, d, v.eth);
            chk({mode_req(v.mode), " R11 flags"}, {6'd0, irq_hi, irq}, {6'd0, v.efh, v.ef});
        end

        // R2 control readback and unused address
        wr(2'd2, 8'h2E);
        rd(2'd2, d); chk("R2 ctrl readback", d, 8'h2E);
        wr(2'd0, 8'h11); wr(2'd1, 8'h22);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); chk("R2 addr3 reads zero", d, 8'h00);
        rd(2'd0, d); chk("R2 addr3 write ignored low", d, 8'h11);
        rd(2'd1, d); chk("R2 addr3 write ignored high", d, 8'h22);
        rd(2'd2, d); chk("R2 addr3 write ignored ctrl", d, 8'h2E);

        // R3 stopped
        setup(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 8'h00);
        repeat (30) @(negedge clk);
        rd(2'd0, d); chk("R3 held while stopped", d, 8'h05);
        rd(2'd2, d); chk("R2 ctrl after setup", d, 8'h21);

        // R4 first-count edge, /12 then /4
        setup(2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        repeat (11) @(negedge clk);
        rd(2'd0, d); chk("R4 slow before 12th edge", d, 8'h00);
        @(negedge clk);
        rd(2'd0, d); chk("R4 slow at 12th edge", d, 8'h01);
        setup(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        rd(2'd0, d); chk("R4 fast before 4th edge", d, 8'h00);
        @(negedge clk);
        rd(2'd0, d); chk("R4 fast at 4th edge", d, 8'h01);

        // R5 gating
        gate_pin = 1'b0;
        setup(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        repeat (48) @(negedge clk);
        rd(2'd0, d); chk("R5 gate low blocks", d, 8'h00);
        gate_pin = 1'b1;
        repeat (48) @(negedge clk);
        rd(2'd0, d); chk("R5 gate high counts", d, 8'h04);
        gate_pin = 1'b0;

        // R6 external falling edges
        setup(2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        for (int k = 0; k < 5; k++) begin
            cnt_pin = 1'b1; repeat (3) @(negedge clk);
            cnt_pin = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R6 five falling edges", d, 8'h05);
        cnt_pin = 1'b1;
        repeat (6) @(negedge clk);
        rd(2'd0, d); chk("R6 rising edge ignored", d, 8'h05);
        cnt_pin = 1'b0;
        repeat (6) @(negedge clk);

        // R10 split: high byte ignores gate
        setup(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        repeat (24) @(negedge clk);
        rd(2'd0, d); chk("R10 low gated off", d, 8'h00);
        rd(2'd1, d); chk("R10 high counts prescaler", d, 8'h02);

        // R11 overflow coinciding with ack
        setup(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF);
        ack = 1'b1;
        repeat (4) @(negedge clk);
        ack = 1'b0;
        chk("R11 set beats ack", {7'd0, irq}, 8'h01);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk("R11 ack clears", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h40);
        chk("R11 software set", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h00);
        chk("R11 software clear", {7'd0, irq}, 8'h00);

        // R11 high flag acknowledge is separate
        setup(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF);
        repeat (12) @(negedge clk);
        chk("R11 both flags set", {6'd0, irq_hi, irq}, 8'h03);
        ack_hi = 1'b1; @(negedge clk); ack_hi = 1'b0;
        chk("R11 ack_hi clears only high", {6'd0, irq_hi, irq}, 8'h01);

        // R12 write beats count
        setup(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        wr(2'd0, 8'h40);
        rd(2'd0, d); chk("R12 write wins", d, 8'h40);
        repeat (4) @(negedge clk);
        rd(2'd0, d); chk("R12 count resumes", d, 8'h41);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule